// File: doc/BRIEF.md
# Serial NOR Flash Slave Model

This block acts as the target of a mode-0 serial peripheral bus and answers like a small serial NOR flash part whose storage is an on-chip byte array. A host lowers the active-low select, clocks in a one-byte opcode and then, depending on the opcode, a 24-bit address, data bytes or both. Read-type opcodes return bytes on the serial output while its enable is raised. Write-type opcodes change internal state when the select returns high. All four serial pins are sampled by the block's own system clock, which must run several times faster than the serial clock. Edges on the serial clock are found by comparing each sample with the one before it.

Program and erase start an internal cycle timed by a counter. While that cycle runs, the block turns away every opcode except the status read. A deep power-down state turns away every opcode except the release opcode. An opcode that changes state is dropped unless the select rises after a whole number of bytes.

Top module: `spf_slave`

## Requirements
- R1: Input bits are taken on rising edges of `sclk` and output bits change only after falling edges, most significant bit first. `miso` does not change while `sclk` stays high.
- R2: Opcode 03h followed by a 24-bit address returns the array byte at the low ADDR_W address bits. Successive bytes come from successive addresses, and after address 2^ADDR_W-1 the next byte comes from address 0.
- R3: Opcode 05h returns the status byte for as long as the select stays low. Bit 0 is the busy flag, bit 1 is the write-enable flag, and bits 7..2 read 0. The status byte is read live, and it is also served during an internal cycle.
- R4: Opcode 9Fh returns the 24-bit DEV_ID in three bytes, most significant byte first. Any further bytes read 00h.
- R5: Opcode 06h sets the write-enable flag and opcode 04h clears it. Each takes effect when the select rises.
- R6: Opcode 02h followed by an address and data bytes ANDs the data into the page that holds the address (2^PAGE_W bytes). Data that runs past the page end wraps to the page start. The opcode has no effect unless the write-enable flag is set.
- R7: Opcode D8h followed by an address sets every byte of the enclosing sector (2^SECT_W bytes) to FFh, provided the write-enable flag is set.
- R8: Opcodes 06h, 04h, 02h, D8h and B9h are discarded when the select rises after a bit count that is not a multiple of 8.
- R9: An accepted program or erase sets the busy flag for PROG_CYC or ERASE_CYC clock cycles. During that time every opcode except 05h is ignored, including array reads and B9h. The write-enable flag clears when the cycle ends.
- R10: Opcode B9h enters power-down. In power-down every opcode except ABh is ignored. ABh followed by three dummy bytes returns SIG on every further byte, and the block leaves power-down when the select rises.
- R11: `miso_oe` is low whenever the select has been high for a clock cycle, and it is low during the opcode, address and dummy bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset; the array resets to FFh |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
The hardest situations to reach are opcodes that arrive during an internal program or erase cycle, and a select that rises partway through a byte. The bench gives the internal cycles lengths that span several whole serial transactions. It then issues status reads, array reads and a power-down request while the busy flag is still set. It also drives single bits on the bus, so the select rises after 11 or 43 clocks, and confirms through the status byte and array reads that nothing changed.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_STAT  = 8'h05;
    localparam logic [7:0] CMD_IDENT = 8'h9F;
    localparam logic [7:0] CMD_WEN   = 8'h06;
    localparam logic [7:0] CMD_WDIS  = 8'h04;
    localparam logic [7:0] CMD_PROG  = 8'h02;
    localparam logic [7:0] CMD_ERASE = 8'hD8;
    localparam logic [7:0] CMD_SLEEP = 8'hB9;
    localparam logic [7:0] CMD_WAKE  = 8'hAB;

    // Decides whether an opcode is served, given busy and power-down state
    function automatic logic cmd_admit(input logic [7:0] op, input logic busy, input logic sleep);
        if (busy)  return op == CMD_STAT;
        if (sleep) return op == CMD_WAKE;
        return op inside {CMD_READ, CMD_STAT, CMD_IDENT, CMD_WEN, CMD_WDIS,
                          CMD_PROG, CMD_ERASE, CMD_SLEEP, CMD_WAKE};
    endfunction
endpackage

// File: rtl/spf_busy_timer.sv
`timescale 1ns/1ps
module spf_busy_timer #(
    parameter int PROG_CYC  = 1000,
    parameter int ERASE_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_erase,
    output logic busy,
    output logic done
);
    localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = is_erase ? CW'(ERASE_CYC) : CW'(PROG_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9
endmodule

// File: rtl/spf_mem_array.sv
`timescale 1ns/1ps
module spf_mem_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4,
    parameter int SECT_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [7:0]               rdata,
    input  logic                     prog_go,
    input  logic [ADDR_W-PAGE_W-1:0] prog_page,
    input  logic [(8<<PAGE_W)-1:0]   prog_data,
    input  logic [(1<<PAGE_W)-1:0]   prog_mask,
    input  logic                     erase_go,
    input  logic [ADDR_W-SECT_W-1:0] erase_sect
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_B = 1 << PAGE_W;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        logic [ADDR_W-1:0] a;
        for (int i = 0; i < DEPTH; i++) begin
            a = ADDR_W'(i);
            mem_d[i] = mem_q[i];
            if (erase_go && a[ADDR_W-1:SECT_W] == erase_sect)
                mem_d[i] = 8'hFF;
        end
        if (prog_go) begin
            for (int j = 0; j < PAGE_B; j++) begin
                a = {prog_page, PAGE_W'(j)};
                if (prog_mask[j])
                    mem_d[a] = mem_q[a] & prog_data[j*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_go && erase_go)); // R7
endmodule

// File: rtl/spf_slave.sv
`timescale 1ns/1ps
module spf_slave
    import spf_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          PAGE_W    = 4,
    parameter int          SECT_W    = 6,
    parameter int          PROG_CYC  = 1000,
    parameter int          ERASE_CYC = 2000,
    parameter logic [23:0] DEV_ID    = 24'h3C4D5E,
    parameter logic [7:0]  SIG       = 8'h6B
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    localparam int PAGE_B = 1 << PAGE_W;

    typedef struct packed {
        logic                sclk;
        logic                csn;
        logic [2:0]          bitc;
        logic [2:0]          bytec;
        logic [6:0]          rx;
        logic [7:0]          op;
        logic                acc;
        logic [23:0]         addr;
        logic [PAGE_W-1:0]   pidx;
        logic [PAGE_B*8-1:0] pbuf;
        logic [PAGE_B-1:0]   pmask;
        logic [7:0]          tx;
        logic                so;
        logic                oe;
        logic                wel;
        logic                dp;
    } st_t;

    st_t        d, q;
    logic       prog_go, erase_go, busy, tmr_done;
    logic [7:0] mem_rdata;

    spf_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) tmr_i (
        .clk(clk), .rst_n(rst_n), .start(prog_go | erase_go),
        .is_erase(erase_go), .busy(busy), .done(tmr_done));

    spf_mem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W)) mem_i (
        .clk(clk), .rst_n(rst_n), .raddr(q.addr[ADDR_W-1:0]), .rdata(mem_rdata),
        .prog_go(prog_go), .prog_page(q.addr[ADDR_W-1:PAGE_W]),
        .prog_data(q.pbuf), .prog_mask(q.pmask),
        .erase_go(erase_go), .erase_sect(q.addr[ADDR_W-1:SECT_W]));

    always_comb begin
        logic [7:0] byte_in, out_byte;
        logic       out_vld;
        d        = q;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        byte_in  = {q.rx, mosi};
        out_byte = 8'h00;
        out_vld  = 1'b0;
        d.sclk   = sclk;
        d.csn    = cs_n;
        if (tmr_done) d.wel = 1'b0;
        if (cs_n) begin
            if (!q.csn && q.acc && q.bitc == 3'd0) begin
                case (q.op)
                    CMD_WEN:   d.wel = 1'b1;
                    CMD_WDIS:  d.wel = 1'b0;
                    CMD_SLEEP: d.dp  = 1'b1;
                    CMD_WAKE:  d.dp  = 1'b0;
                    CMD_PROG:  prog_go  = q.wel && q.bytec >= 3'd5;
                    CMD_ERASE: erase_go = q.wel && q.bytec >= 3'd4;
                    default: ;
                endcase
            end
            d.bitc  = '0;
            d.bytec = '0;
            d.acc   = 1'b0;
            d.oe    = 1'b0;
            d.op    = '0;
        end else if (sclk && !q.sclk) begin
            d.rx   = byte_in[6:0];
            d.bitc = q.bitc + 1'b1;
            if (q.bitc == 3'd7) begin
                if (q.bytec != 3'd7) d.bytec = q.bytec + 1'b1;
                if (q.bytec == 3'd0) begin
                    d.op    = byte_in;
                    d.acc   = cmd_admit(byte_in, busy, q.dp);
                    d.pmask = '0;
                end else if (q.bytec <= 3'd3) begin
                    d.addr = {q.addr[15:0], byte_in};
                    if (q.bytec == 3'd3) d.pidx = byte_in[PAGE_W-1:0];
                end else if (q.acc && q.op == CMD_PROG) begin
                    d.pbuf[q.pidx*8 +: 8] = byte_in;
                    d.pmask[q.pidx]       = 1'b1;
                    d.pidx                = q.pidx + 1'b1;
                end
            end
        end else if (!sclk && q.sclk) begin
            if (q.bitc == 3'd0 && q.bytec != 3'd0) begin
                if (q.acc) begin
                    case (q.op)
                        CMD_READ: if (q.bytec >= 3'd4) begin
                            out_vld = 1'b1;
                            out_byte = mem_rdata;
                            d.addr[ADDR_W-1:0] = q.addr[ADDR_W-1:0] + 1'b1;
                        end
                        CMD_STAT: begin
                            out_vld  = 1'b1;
                            out_byte = {6'b0, q.wel, busy};
                        end
                        CMD_IDENT: begin
                            out_vld = 1'b1;
                            case (q.bytec)
                                3'd1: out_byte = DEV_ID[23:16];
                                3'd2: out_byte = DEV_ID[15:8];
                                3'd3: out_byte = DEV_ID[7:0];
                                default: out_byte = 8'h00;
                            endcase
                        end
                        CMD_WAKE: if (q.bytec >= 3'd4) begin
                            out_vld = 1'b1;
                            out_byte = SIG;
                        end
                        default: ;
                    endcase
                end
                d.oe = out_vld;
                if (out_vld) begin
                    d.so = out_byte[7];
                    d.tx = {out_byte[6:0], 1'b0};
                end
            end else if (q.oe) begin
                d.so = q.tx[7];
                d.tx = {q.tx[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.csn  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign miso    = q.so;
    assign miso_oe = q.oe;

    AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && q.sclk && sclk) |=> $stable(miso)); // R1
    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && q.csn) |-> !miso_oe); // R11
    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.dp |-> !busy); // R10
    AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |=> !q.wel); // R9
    AST_START_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(q.wel)); // R6
endmodule

// File: tb/spf_slave_tb.sv
`timescale 1ns/1ps
module spf_slave_tb_top;
    localparam logic [23:0] ID  = 24'h3C4D5E;
    localparam logic [7:0]  SG  = 8'h6B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    always #4 clk = ~clk;

    spf_slave #(.ADDR_W(8), .PAGE_W(4), .SECT_W(6), .PROG_CYC(1000),
                .ERASE_CYC(2000), .DEV_ID(ID), .SIG(SG)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe));

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   vec  = 0;
    int   miss = 0;
    bit   ended = 0;

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
            $finish;
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(logic [7:0] v, string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: assembles bytes seen on miso and compares against the queue
    logic [7:0] mon_sh = 8'h00;
    int         mon_n  = 0;
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            mon_n = 0;
        end else if (miso_oe) begin
            mon_sh = {mon_sh[6:0], miso};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) begin
                    vec++;
                    miss++;
                    $display("FAIL R11: unexpected output byte actual %0h expected none", mon_sh);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(e.tag, {24'h0, mon_sh}, {24'h0, e.val});
                end
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(logic b);
        mosi = b;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
        sclk = 1'b0;
    endtask

    task automatic byte_out(logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
    endtask

    task automatic cs_on();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic cs_off();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(6);
        if (exp_q.size() != 0) begin
            vec++;
            miss++;
            $display("FAIL %s: actual missing expected %0h", exp_q[0].tag, exp_q[0].val);
            exp_q.delete();
        end
    endtask

    task automatic cmd_addr(logic [7:0] op, logic [23:0] a);
        byte_out(op);
        byte_out(a[23:16]);
        byte_out(a[15:8]);
        byte_out(a[7:0]);
    endtask

    task automatic single(logic [7:0] op);
        cs_on();
        byte_out(op);
        cs_off();
    endtask

    task automatic rd(logic [23:0] a, int n);
        cs_on();
        cmd_addr(8'h03, a);
        for (int i = 0; i < n; i++) byte_out(8'h00);
        cs_off();
    endtask

    task automatic status(logic [7:0] e, string tag);
        push(e, tag);
        push(e, tag);
        cs_on();
        byte_out(8'h05);
        byte_out(8'h00);
        byte_out(8'h00);
        cs_off();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vec++;
        miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(5);

        // R11: reset state, no output enable
        chk("R11 reset", {31'b0, miso_oe}, 32'h0);

        // R3: status after reset, repeated while select low
        status(8'h00, "R3 status reset");

        // R1, R4: identification bytes MSB first, then 00h
        push(ID[23:16], "R1 R4 id");
        push(ID[15:8],  "R1 R4 id");
        push(ID[7:0],   "R1 R4 id");
        push(8'h00,     "R4 id tail");
        cs_on();
        byte_out(8'h9F);
        for (int i = 0; i < 4; i++) byte_out(8'h00);
        cs_off();

        // R2: erased array reads FFh; R11: no enable during address phase
        push(8'hFF, "R2 read erased");
        push(8'hFF, "R2 read erased");
        cs_on();
        byte_out(8'h03);
        byte_out(8'h00);
        chk("R11 address phase", {31'b0, miso_oe}, 32'h0);
        byte_out(8'h00);
        byte_out(8'h10);
        byte_out(8'h00);
        byte_out(8'h00);
        cs_off();
        chk("R11 after select high", {31'b0, miso_oe}, 32'h0);

        // R6: program without write enable has no effect
        cs_on();
        cmd_addr(8'h02, 24'h000020);
        byte_out(8'hA5);
        cs_off();
        wait_clk(1100);
        push(8'hFF, "R6 no wel");
        rd(24'h000020, 1);
        status(8'h00, "R6 no wel status");

        // R5: write enable / disable
        single(8'h06);
        status(8'h02, "R5 wen");
        single(8'h04);
        status(8'h00, "R5 wdis");

        // R8: write enable with 11 clocks is discarded
        cs_on();
        byte_out(8'h06);
        bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
        cs_off();
        status(8'h00, "R8 wen abort");

        // R6, R9: program with page wrap, busy visible, reads ignored
        single(8'h06);
        cs_on();
        cmd_addr(8'h02, 24'h00002E);
        byte_out(8'h11); byte_out(8'h22); byte_out(8'h33);
        cs_off();
        status(8'h03, "R9 busy status");
        cs_on();
        cmd_addr(8'h03, 24'h00002E);
        byte_out(8'h00);
        chk("R9 read ignored while busy", {31'b0, miso_oe}, 32'h0);
        cs_off();
        wait_clk(1100);
        status(8'h00, "R9 done wel cleared");
        push(8'h11, "R6 program");
        push(8'h22, "R6 program");
        rd(24'h00002E, 2);
        push(8'h33, "R6 page wrap");
        rd(24'h000020, 1);

        // R6: programming only clears bits
        single(8'h06);
        cs_on();
        cmd_addr(8'h02, 24'h00002E);
        byte_out(8'hF0); byte_out(8'h0F);
        cs_off();
        wait_clk(1100);
        push(8'h10, "R6 and");
        push(8'h02, "R6 and");
        rd(24'h00002E, 2);

        // R2: read wraps past top address
        single(8'h06);
        cs_on();
        cmd_addr(8'h02, 24'h000000);
        byte_out(8'h5A);
        cs_off();
        wait_clk(1100);
        push(8'hFF, "R2 wrap");
        push(8'hFF, "R2 wrap");
        push(8'h5A, "R2 wrap");
        rd(24'h0000FE, 3);

        // R8: program ending 3 bits past a byte is discarded
        single(8'h06);
        cs_on();
        cmd_addr(8'h02, 24'h000040);
        byte_out(8'h55);
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
        cs_off();
        status(8'h02, "R8 prog abort status");
        push(8'hFF, "R8 prog abort data");
        rd(24'h000040, 1);
        single(8'h04);

        // R7, R9, R10: erase, power-down request ignored while busy
        single(8'h06);
        cs_on();
        cmd_addr(8'hD8, 24'h000030);
        cs_off();
        single(8'hB9);
        status(8'h03, "R9 erase busy");
        wait_clk(2100);
        status(8'h00, "R10 sleep ignored while busy");
        push(8'hFF, "R7 erase");
        push(8'hFF, "R7 erase");
        rd(24'h00002E, 2);
        push(8'hFF, "R7 erase");
        rd(24'h000000, 1);

        // R10: power-down, everything but release ignored
        single(8'hB9);
        cs_on();
        byte_out(8'h05);
        byte_out(8'h00);
        chk("R10 status ignored asleep", {31'b0, miso_oe}, 32'h0);
        cs_off();
        single(8'h06);
        push(SG, "R10 signature");
        push(SG, "R10 signature");
        cs_on();
        cmd_addr(8'hAB, 24'h000000);
        byte_out(8'h00);
        byte_out(8'h00);
        cs_off();
        status(8'h00, "R10 awake, wen ignored");

        wait_clk(20);
        finish_run();
    end
endmodule